// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is a slave receiver for stereo PCM audio on a three-wire serial link. The link has a bit clock, a frame clock whose level tells which channel is on the line, and one data line. The block runs directly on the bit clock and samples the frame clock and the data on each rising edge. It turns the serial stream into parallel left and right words of `WORD_W` bits, in two's complement, and raises a one-cycle valid strobe once for each complete stereo frame.

A three-bit format input picks the framing. The choices are left-justified, I2S, and right-justified with 16, 18, 20 or 24 bit words. Left-justified and I2S words are placed at the top of the output word. Right-justified words are taken from the tail of each half-frame and sign-extended. The supported bit-clock to frame-clock ratios are 32, 48, 64, 96 and 128, which gives half-frames of 16 to 64 bit clocks.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `smp_vld` is 0 and both sample outputs are 0.
- R2: Format code 0 (left-justified). The left channel is sent while the frame clock is high and the right channel while it is low. The MSB is the first bit sampled after a frame-clock change. At most the first 24 bits of a half-frame are kept; later bits in that half-frame have no effect on the output.
- R3: In left-justified and I2S framing, a half-frame shorter than 24 bits (16 bits at a ratio of 32) is placed at the top of the output word, and the unused low bits are 0.
- R4: Format code 1 (I2S). The left channel is sent while the frame clock is low. The MSB arrives one bit clock after the frame-clock change, and the bit sampled at the change still belongs to the previous channel.
- R5: Format code 2 (right-justified, 16 bits). The last 16 bits before the frame-clock change form the word, and the LSB is the last of them. The word is sign-extended to 24 bits. Earlier bits in the half-frame have no effect.
- R6: Format code 3 (right-justified, 24 bits). The last 24 bits before the frame-clock change form the word.
- R7: Format code 4 (right-justified, 20 bits). The last 20 bits before the frame-clock change form the word, sign-extended.
- R8: Format code 5 (right-justified, 18 bits). The last 18 bits before the frame-clock change form the word, sign-extended.
- R9: `smp_vld` is high for exactly one bit clock per stereo frame. It goes high at the edge that samples the first bit of the next left half-frame after the right half-frame has ended. Both sample outputs change only together with the strobe and hold their values in between.
- R10: After reset, a half-frame already in progress is discarded. The first strobe comes only after one complete left half-frame and the right half-frame that follows it.
- R11: The unused format codes 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; every register is clocked on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Framing format code (see R2, R4 to R8, R11) |
| lrclk | input | 1 | Frame clock; its level marks the channel on the line |
| sdata | input | 1 | Serial data, MSB first |
| left_smp | output | WORD_W | Last complete left sample |
| right_smp | output | WORD_W | Last complete right sample |
| smp_vld | output | 1 | One-cycle strobe when a stereo frame is complete |

## Verification
The bench fills the unused parts of each half-frame with alternating junk bits. A receiver that keeps shifting past 24 bits in left-justified mode, or that keeps bits from before the right-justified window, therefore returns wrong words. I2S is driven with the frame clock one bit ahead of the channel slots, so a design that treats I2S like left-justified reports words shifted by one bit with the channels swapped. Each run starts with a short right-channel lead-in right after reset, which catches a strobe raised from a partial first half-frame. The right-justified widths use negative words so that a missing sign extension shows up. The strobe is compared on every bit clock, so an early, late or doubled pulse is reported.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  // framing codes carried on fmt_sel
  typedef enum logic [2:0] {
    FMT_LJ    = 3'd0,
    FMT_I2S   = 3'd1,
    FMT_RJ16  = 3'd2,
    FMT_RJ24  = 3'd3,
    FMT_RJ20  = 3'd4,
    FMT_RJ18  = 3'd5,
    FMT_RSV6  = 3'd6,
    FMT_RSV7  = 3'd7
  } fmt_e;

  // true when the slot starts one bit clock after the frame clock change
  function automatic logic fmt_is_delayed(input logic [2:0] f);
    return f == FMT_I2S;
  endfunction

  // word length of a right-justified format, 0 for top-aligned formats
  function automatic int unsigned fmt_tail_bits(input logic [2:0] f);
    int unsigned n;
    case (f)
      FMT_RJ16: n = 16;
      FMT_RJ18: n = 18;
      FMT_RJ20: n = 20;
      FMT_RJ24: n = 24;
      default:  n = 0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sarx_chan_norm.sv
module sarx_chan_norm
  import sarx_pkg::*;
(
  input  logic       bclk,
  input  logic       rst_n,
  input  logic [2:0] fmt_sel,
  input  logic       lrclk,
  input  logic       sdata,
  output logic       slot_left,
  output logic       slot_bit,
  output logic       slot_edge
);

  localparam int unsigned PRIME_CYC = 2;
  localparam int unsigned PW = $clog2(PRIME_CYC + 1);

  logic          lr_q;
  logic          chan_q;
  logic [PW-1:0] prime_cnt;
  logic          primed;
  logic          delayed;

  assign delayed = fmt_is_delayed(fmt_sel);
  assign primed  = (prime_cnt == PW'(PRIME_CYC));

  // normalised channel: 1 = left slot
  always_comb begin
    if (delayed) slot_left = ~lr_q;
    else         slot_left = lrclk;
  end

  assign slot_bit  = sdata;
  assign slot_edge = primed && (slot_left != chan_q);

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      lr_q      <= 1'b0;
      chan_q    <= 1'b0;
      prime_cnt <= '0;
    end else begin
      lr_q   <= lrclk;
      chan_q <= slot_left;
      if (!primed) prime_cnt <= prime_cnt + 1'b1;
    end
  end

  // R4
  i2s_lag_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (delayed && slot_edge) |-> ($past(lrclk) != $past(lrclk, 2)));

endmodule

// File: rtl/sarx_word_asm.sv
module sarx_word_asm
  import sarx_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic [2:0]        fmt_sel,
  input  logic              slot_left,
  input  logic              slot_bit,
  input  logic              slot_edge,
  output logic              word_done,
  output logic              word_is_left,
  output logic [WORD_W-1:0] word_val
);

  localparam int unsigned CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     bit_cnt;
  logic              seen_edge;
  int unsigned       tail_n;
  logic              keep_shifting;

  // top-align the bits gathered so far, zero below
  function automatic logic [WORD_W-1:0] top_align(input logic [WORD_W-1:0] v,
                                                  input logic [CW-1:0] c);
    logic [WORD_W-1:0] r;
    if (c == '0) r = '0;
    else         r = v << (CNT_FULL - c);
    return r;
  endfunction

  // sign-extend the low n bits of v
  function automatic logic [WORD_W-1:0] sign_ext(input logic [WORD_W-1:0] v,
                                                 input int unsigned n);
    logic [WORD_W-1:0] r;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (i < n) r[i] = v[i];
      else       r[i] = v[n-1];
    end
    return r;
  endfunction

  assign tail_n        = fmt_tail_bits(fmt_sel);
  assign keep_shifting = (tail_n != 0) || (bit_cnt < CNT_FULL);

  always_comb begin
    if (tail_n != 0) word_val = sign_ext(shreg, tail_n);
    else             word_val = top_align(shreg, bit_cnt);
  end

  // the half-frame that ends now belongs to the opposite channel
  assign word_done    = slot_edge && seen_edge;
  assign word_is_left = ~slot_left;

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      seen_edge <= 1'b0;
    end else if (slot_edge) begin
      seen_edge <= 1'b1;
      shreg     <= {{(WORD_W-1){1'b0}}, slot_bit};
      bit_cnt   <= CW'(1);
    end else begin
      if (keep_shifting) shreg <= {shreg[WORD_W-2:0], slot_bit};
      if (bit_cnt < CNT_FULL) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R2
  restart_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    slot_edge |=> (bit_cnt == CW'(1)));

endmodule

// File: rtl/sarx_frame_pair.sv
module sarx_frame_pair #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic              word_is_left,
  input  logic [WORD_W-1:0] word_val,
  output logic [WORD_W-1:0] left_smp,
  output logic [WORD_W-1:0] right_smp,
  output logic              smp_vld
);

  logic [WORD_W-1:0] left_hold;
  logic              left_ok;
  logic              frame_close;

  assign frame_close = word_done && !word_is_left && left_ok;

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      left_hold <= '0;
      left_ok   <= 1'b0;
      left_smp  <= '0;
      right_smp <= '0;
      smp_vld   <= 1'b0;
    end else begin
      smp_vld <= 1'b0;
      if (word_done && word_is_left) begin
        left_hold <= word_val;
        left_ok   <= 1'b1;
      end else if (frame_close) begin
        left_smp  <= left_hold;
        right_smp <= word_val;
        smp_vld   <= 1'b1;
        left_ok   <= 1'b0;
      end
    end
  end

  // R9
  vld_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    smp_vld |=> !smp_vld);

  // R9
  out_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !smp_vld |-> ($stable(left_smp) && $stable(right_smp)));

  // R10
  close_vld_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_close |=> smp_vld);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic [2:0]        fmt_sel,
  input  logic              lrclk,
  input  logic              sdata,
  output logic [WORD_W-1:0] left_smp,
  output logic [WORD_W-1:0] right_smp,
  output logic              smp_vld
);

  logic              slot_left;
  logic              slot_bit;
  logic              slot_edge;
  logic              word_done;
  logic              word_is_left;
  logic [WORD_W-1:0] word_val;

  sarx_chan_norm u_norm (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .lrclk     (lrclk),
    .sdata     (sdata),
    .slot_left (slot_left),
    .slot_bit  (slot_bit),
    .slot_edge (slot_edge)
  );

  sarx_word_asm #(.WORD_W(WORD_W)) u_asm (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .fmt_sel      (fmt_sel),
    .slot_left    (slot_left),
    .slot_bit     (slot_bit),
    .slot_edge    (slot_edge),
    .word_done    (word_done),
    .word_is_left (word_is_left),
    .word_val     (word_val)
  );

  sarx_frame_pair #(.WORD_W(WORD_W)) u_pair (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .word_done    (word_done),
    .word_is_left (word_is_left),
    .word_val     (word_val),
    .left_smp     (left_smp),
    .right_smp    (right_smp),
    .smp_vld      (smp_vld)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge bclk)
    !rst_n |=> (!smp_vld && left_smp == '0 && right_smp == '0));

endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] left_smp, right_smp;
  logic        smp_vld;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  serial_audio_rx #(.WORD_W(24)) u0 (
    .bclk(clk), .rst_n(rst_n), .fmt_sel(fmt), .lrclk(lrclk), .sdata(sdata),
    .left_smp(left_smp), .right_smp(right_smp), .smp_vld(smp_vld)
  );

  // reference stream: channel slot (1 = left), data bit, expected strobe and words
  bit          ch_q[$];
  bit          d_q[$];
  bit          ev_q[$];
  logic [23:0] el_q[$];
  logic [23:0] er_q[$];
  bit          pend;
  logic [23:0] pend_l, pend_r;

  function automatic int tail_len(input int f);
    if (f == 2) return 16;
    if (f == 3) return 24;
    if (f == 4) return 20;
    if (f == 5) return 18;
    return 0;
  endfunction

  // expected output word from the sent value
  function automatic logic [23:0] expect_word(input int f, input int half, input logic [23:0] w);
    int n;
    int k;
    logic signed [23:0] s;
    n = tail_len(f);
    if (n != 0) begin
      s = $signed(w << (24 - n));
      return s >>> (24 - n);
    end
    k = (half < 24) ? half : 24;
    return (w >> (24 - k)) << (24 - k);
  endfunction

  task automatic push(input bit ch, input bit d, input bit v,
                      input logic [23:0] l, input logic [23:0] r);
    ch_q.push_back(ch); d_q.push_back(d); ev_q.push_back(v);
    el_q.push_back(l); er_q.push_back(r);
  endtask

  task automatic add_half(input bit ch, input int f, input int half, input logic [23:0] w);
    int n;
    bit b;
    n = tail_len(f);
    for (int p = 0; p < half; p++) begin
      b = p[0];                       // junk filler
      if (n != 0) begin
        if (p >= half - n) b = w[n - 1 - (p - (half - n))];
      end else if (p < 24) begin
        b = w[23 - p];
      end
      if (ch && p == 0 && pend) begin
        push(ch, b, 1'b1, pend_l, pend_r);
        pend = 1'b0;
      end else begin
        push(ch, b, 1'b0, 24'h0, 24'h0);
      end
    end
  endtask

  task automatic add_frame(input int f, input int half, input logic [23:0] l, input logic [23:0] r);
    add_half(1'b1, f, half, l);
    add_half(1'b0, f, half, r);
    pend   = 1'b1;
    pend_l = expect_word(f, half, l);
    pend_r = expect_word(f, half, r);
  endtask

  task automatic run(input string tag, input int f, input int half);
    int len;
    bit nx;
    ch_q.delete(); d_q.delete(); ev_q.delete(); el_q.delete(); er_q.delete();
    pend = 1'b0;
    for (int i = 0; i < 5; i++) push(1'b0, i[0], 1'b0, 24'h0, 24'h0); // partial lead-in (R10)
    add_frame(f, half, 24'h7FFFFF, 24'h800000);
    add_frame(f, half, 24'h123456, 24'hEDCBA9);
    add_frame(f, half, 24'h00F0C3, 24'hA5A58F);
    add_frame(f, half, 24'h000001, 24'hFFFFFE);
    add_half(1'b1, f, half, 24'h0);
    len = ch_q.size();
    @(negedge clk);
    rst_n = 1'b0;
    fmt   = f[2:0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < len; t++) begin
      if (f == 1) begin
        nx = (t + 1 < len) ? ch_q[t + 1] : ch_q[t];
        lrclk = ~nx;                  // frame clock leads slots by one bit, low = left
      end else begin
        lrclk = ch_q[t];
      end
      sdata = d_q[t];
      @(posedge clk);
      #1;
      checks++;
      if (smp_vld !== ev_q[t]) begin
        errors++;
        $display("FAIL %s R9 strobe t=%0d actual %0b expected %0b", tag, t, smp_vld, ev_q[t]);
      end
      if (ev_q[t]) begin
        checks++;
        if (left_smp !== el_q[t] || right_smp !== er_q[t]) begin
          errors++;
          $display("FAIL %s words t=%0d actual %h/%h expected %h/%h",
                   tag, t, left_smp, right_smp, el_q[t], er_q[t]);
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (smp_vld !== 1'b0 || left_smp !== 24'h0 || right_smp !== 24'h0) begin
      errors++;
      $display("FAIL R1 reset state actual %b %h %h expected 0 0 0", smp_vld, left_smp, right_smp);
    end
    run("R2 R10 lj x64", 0, 32);
    run("R2 lj x128", 0, 64);
    run("R3 lj x32", 0, 16);
    run("R4 i2s x64", 1, 32);
    run("R4 i2s x48", 1, 24);
    run("R3 R4 i2s x32", 1, 16);
    run("R5 rj16 x64", 2, 32);
    run("R5 rj16 x32", 2, 16);
    run("R6 rj24 x64", 3, 32);
    run("R7 rj20 x48", 4, 24);
    run("R8 rj18 x96", 5, 48);
    run("R11 code6 x64", 6, 32);
    run("R11 code7 x96", 7, 48);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule